// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block is the front end of an SDRAM controller that brings the memory out of power-up and then keeps it refreshed. Once reset is released it owns the command bus. It holds the bus quiet with clock-enable and the data masks high for the required settling pause. It then closes every bank, programs the mode word and runs a burst of auto-refresh cycles, and waits out each command's recovery time before the next one. When the last recovery time has passed, it raises a sticky ready flag and hands the bus to user traffic.

From then on a free-running interval counter raises a refresh request at a fixed cadence. The cadence is derived from the clock frequency so that 4096 refreshes fit in 64 ms, about one every 15.6 µs. A downstream arbiter finishes its current work and acknowledges. The sequencer then closes all banks and issues one auto-refresh, with user traffic blocked for the precharge and refresh recovery times. Timing values are given in nanoseconds and the clock in MHz, and the block converts them to whole cycles. The mode word fields are also parameters.

Top module: `sdr_bringup_seq`

## Requirements
- R1: For PAUSE_US×CLK_MHZ cycles after reset release the command bus carries NOP ({cs_n,ras_n,cas_n,we_n}=0111), with clock-enable high and every DQM bit high.
- R2: The first command after the pause is precharge-all ({cs_n,ras_n,cas_n,we_n}=0010 with address bit 10 high, all other address and bank bits low), issued in the cycle right after the last pause cycle.
- R3: The mode-set command (0000) follows the precharge-all by exactly ceil(TRP_NS×CLK_MHZ/1000) cycles, minimum 2, with NOPs between. The cycle after it is a NOP and the bank bits are zero.
- R4: During mode-set the address carries burst-length code on bits 2:0, wrap type on bit 3 (1 = interleaved), CAS latency on bits 6:4 (2 or 3), single-write mode on bit 9, and zero elsewhere.
- R5: TMRD_CYC cycles after mode-set, eight (INIT_REFS) auto-refresh commands (0001) are issued, each ceil(TRC_NS×CLK_MHZ/1000) cycles after the previous one, with NOPs between.
- R6: init_done goes high one refresh-recovery time after the last initial refresh and stays high until reset. DQM drops low in the same cycle.
- R7: After init_done, ref_req rises every floor(REFI_NS×CLK_MHZ/1000) cycles and stays high until taken by ref_ack.
- R8: A request is taken when ref_req, ref_ack and traffic_ok are all high at a clock edge. The next cycle carries precharge-all, and an auto-refresh follows the precharge recovery time later. traffic_ok is low from the precharge cycle for precharge plus refresh recovery cycles, and is otherwise high after init_done.
- R9: ref_ack while ref_req is low, or while a refresh sequence is running, issues no command and leaves ref_req and traffic_ok unchanged.
- R10: While reset is high the bus carries NOP with clock-enable and DQM high, and init_done, ref_req and traffic_ok are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | BANK_W | Bank address |
| sdr_addr | output | ADDR_W | Address bus |
| sdr_dqm | output | DQM_W | Data masks |
| init_done | output | 1 | Initialisation complete, sticky |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_ack | input | 1 | Arbiter grants the refresh slot |
| traffic_ok | output | 1 | User commands may use the bus |

## Verification
On every cycle the assertions check the recovery spacing after each precharge and refresh, the address bit 10 on precharge-all, the NOP after mode-set, the masks staying high until ready, the persistence of ready and of the request, and that no precharge appears after ready unless a request was taken. Only the bench scenarios show the exact cycle of each power-up command, the mode word contents, the refresh cadence, and the effect of an early, late, held or stray acknowledge. The reference model predicts every bus and flag value for each of these.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRE,
        ST_MRS,
        ST_REF,
        ST_GAP,
        ST_RUN,
        ST_RPRE,
        ST_RREF
    } seq_state_e;

    typedef struct packed {
        logic       single_write;
        logic [2:0] cas;
        logic       wrap;
        logic [2:0] burst;
    } mode_t;

    function automatic int ns_to_cyc_up(int ns, int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int ns_to_cyc_dn(int ns, int mhz);
        return (ns * mhz) / 1000;
    endfunction

    function automatic int at_least2(int c);
        return (c < 2) ? 2 : c;
    endfunction

    function automatic logic [11:0] mode_word(mode_t m);
        logic [11:0] w;
        w      = '0;
        w[2:0] = m.burst;
        w[3]   = m.wrap;
        w[6:4] = m.cas;
        w[9]   = m.single_write;
        return w;
    endfunction

endpackage

// File: rtl/sdr_seq_timer.sv
module sdr_seq_timer #(
    parameter int W    = 16,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(INIT);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdr_refresh_pacer.sv
module sdr_refresh_pacer #(
    parameter int PERIOD = 1953
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic take,
    output logic req
);
    localparam int W = (PERIOD < 2) ? 1 : $clog2(PERIOD);

    logic [W-1:0] cnt;
    logic         tick;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= W'(PERIOD - 1);
        else if (cnt == '0)
            cnt <= W'(PERIOD - 1);
        else
            cnt <= cnt - 1'b1;
    end

    // a new tick wins over a take in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            req <= 1'b0;
        else
            req <= tick || (req && !take);
    end
endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2
) (
    input  sdr_cmd_e          cmd,
    input  logic [ADDR_W-1:0] mode_val,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);
    assign {cs_n, ras_n, cas_n, we_n} = 4'(cmd);
    assign ba = '0;

    always_comb begin
        addr = '0;
        unique case (cmd)
            CMD_PRE: addr[10] = 1'b1;
            CMD_MRS: addr     = mode_val;
            default: addr     = '0;
        endcase
    end
endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq
    import sdr_seq_pkg::*;
#(
    parameter int         CLK_MHZ         = 125,
    parameter int         PAUSE_US        = 200,
    parameter int         TRP_NS          = 15,
    parameter int         TRC_NS          = 60,
    parameter int         TMRD_CYC        = 2,
    parameter int         INIT_REFS       = 8,
    parameter int         REFI_NS         = 15625,
    parameter int         ADDR_W          = 12,
    parameter int         BANK_W          = 2,
    parameter int         DQM_W           = 2,
    parameter logic [2:0] BURST_CODE      = 3'b011,
    parameter logic       WRAP_INTERLEAVE = 1'b0,
    parameter int         CAS_LAT         = 3,
    parameter logic       SINGLE_WRITE    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sdr_cke,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic [BANK_W-1:0] sdr_ba,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic [DQM_W-1:0]  sdr_dqm,
    output logic              init_done,
    output logic              ref_req,
    input  logic              ref_ack,
    output logic              traffic_ok
);
    localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
    localparam int RP_CYC    = at_least2(ns_to_cyc_up(TRP_NS, CLK_MHZ));
    localparam int RC_CYC    = at_least2(ns_to_cyc_up(TRC_NS, CLK_MHZ));
    localparam int MRD_CYC   = at_least2(TMRD_CYC);
    localparam int REFI_CYC  = at_least2(ns_to_cyc_dn(REFI_NS, CLK_MHZ));
    localparam int TMR_W     = $clog2(PAUSE_CYC + RP_CYC + RC_CYC + MRD_CYC + 1);
    localparam int RCNT_W    = $clog2(INIT_REFS + 1);

    localparam mode_t MODE_CFG = '{
        single_write: SINGLE_WRITE,
        cas:          (CAS_LAT == 2) ? 3'd2 : 3'd3,
        wrap:         WRAP_INTERLEAVE,
        burst:        BURST_CODE
    };

    seq_state_e        state, after;
    logic [RCNT_W-1:0] ref_cnt;
    logic              done_q;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;
    sdr_cmd_e          cmd;
    logic              take;

    assign take = ref_req && ref_ack && (state == ST_RUN);

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        cmd      = CMD_NOP;
        unique case (state)
            ST_PRE, ST_RPRE: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RP_CYC - 2);
                cmd      = CMD_PRE;
            end
            ST_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(MRD_CYC - 2);
                cmd      = CMD_MRS;
            end
            ST_REF, ST_RREF: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RC_CYC - 2);
                cmd      = CMD_REF;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_PAUSE;
            after   <= ST_PRE;
            ref_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_PAUSE: if (tmr_expired) state <= ST_PRE;
                ST_PRE: begin
                    after <= ST_MRS;
                    state <= ST_GAP;
                end
                ST_MRS: begin
                    after   <= ST_REF;
                    ref_cnt <= '0;
                    state   <= ST_GAP;
                end
                ST_REF: begin
                    ref_cnt <= ref_cnt + RCNT_W'(1);
                    after   <= (ref_cnt == RCNT_W'(INIT_REFS - 1)) ? ST_RUN : ST_REF;
                    state   <= ST_GAP;
                end
                ST_GAP: if (tmr_expired) begin
                    state <= after;
                    if (after == ST_RUN) done_q <= 1'b1;
                end
                ST_RUN: if (take) state <= ST_RPRE;
                ST_RPRE: begin
                    after <= ST_RREF;
                    state <= ST_GAP;
                end
                ST_RREF: begin
                    after <= ST_RUN;
                    state <= ST_GAP;
                end
                default: state <= ST_PAUSE;
            endcase
        end
    end

    sdr_seq_timer #(.W(TMR_W), .INIT(PAUSE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdr_refresh_pacer #(.PERIOD(REFI_CYC)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .run  (done_q),
        .take (take),
        .req  (ref_req)
    );

    sdr_cmd_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_drive (
        .cmd      (cmd),
        .mode_val (ADDR_W'(mode_word(MODE_CFG))),
        .cs_n     (sdr_cs_n),
        .ras_n    (sdr_ras_n),
        .cas_n    (sdr_cas_n),
        .we_n     (sdr_we_n),
        .ba       (sdr_ba),
        .addr     (sdr_addr)
    );

    assign sdr_cke    = 1'b1;
    assign sdr_dqm    = {DQM_W{~done_q}};
    assign init_done  = done_q;
    assign traffic_ok = (state == ST_RUN);
endmodule

// File: rtl/sdr_bringup_seq_chk.sv
module sdr_bringup_seq_chk
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DQM_W  = 2,
    parameter int RP_CYC = 2,
    parameter int RC_CYC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DQM_W-1:0]  dqm,
    input logic              init_done,
    input logic              ref_req,
    input logic              ref_ack,
    input logic              traffic_ok
);
    logic [3:0]  bus;
    logic [3:0]  last_cmd;
    logic [15:0] since;
    logic        active;

    assign bus    = {cs_n, ras_n, cas_n, we_n};
    assign active = (bus != CMD_NOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_cmd <= CMD_NOP;
            since    <= 16'hFFFF;
        end else if (active) begin
            last_cmd <= bus;
            since    <= 16'd1;
        end else if (since != 16'hFFFF) begin
            since <= since + 16'd1;
        end
    end

    a_r1_masks_until_ready: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (&dqm && cke));

    a_r2_pre_all_a10: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_PRE) |-> addr[10]);

    a_r3_mrs_after_rp: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_MRS) |-> (last_cmd == CMD_PRE && since >= 16'(RP_CYC)));

    a_r3_nop_after_mrs: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_MRS) |=> (bus == CMD_NOP));

    a_r5_rc_spacing: assert property (@(posedge clk) disable iff (rst)
        (active && last_cmd == CMD_REF) |-> (since >= 16'(RC_CYC)));

    a_r8_rp_spacing: assert property (@(posedge clk) disable iff (rst)
        (active && last_cmd == CMD_PRE) |-> (since >= 16'(RP_CYC)));

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r7_req_holds: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> ref_req);

    a_r8_take_precharges: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_ack && traffic_ok) |=> (bus == CMD_PRE && !traffic_ok));

    a_r8_open_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        traffic_ok |-> (bus == CMD_NOP && init_done));

    a_r9_no_unasked_pre: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_PRE && init_done) |-> $past(ref_req && ref_ack && traffic_ok));
endmodule

bind sdr_bringup_seq sdr_bringup_seq_chk #(
    .ADDR_W (ADDR_W),
    .DQM_W  (DQM_W),
    .RP_CYC (RP_CYC),
    .RC_CYC (RC_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cke        (sdr_cke),
    .cs_n       (sdr_cs_n),
    .ras_n      (sdr_ras_n),
    .cas_n      (sdr_cas_n),
    .we_n       (sdr_we_n),
    .addr       (sdr_addr),
    .dqm        (sdr_dqm),
    .init_done  (init_done),
    .ref_req    (ref_req),
    .ref_ack    (ref_ack),
    .traffic_ok (traffic_ok)
);

// File: tb/sdr_bringup_seq_test.sv
module sdr_bringup_seq_test;
    localparam int MHZ    = 125;
    localparam int P      = 200 * MHZ;
    localparam int RP0    = (15 * MHZ + 999) / 1000;
    localparam int RP     = (RP0 < 2) ? 2 : RP0;
    localparam int RC0    = (60 * MHZ + 999) / 1000;
    localparam int RC     = (RC0 < 2) ? 2 : RC0;
    localparam int MRD    = 2;
    localparam int REFI   = 15625 * MHZ / 1000;
    localparam int NREF   = 8;
    localparam int F      = P + RP + MRD;
    localparam int D      = F + NREF * RC;
    localparam int LAST   = D + 3 * REFI + 300;
    localparam logic [11:0] MODE_EXP = 12'h200 | 12'h020 | 12'h008 | 12'h002;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_ack = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [1:0]  dqm;
    logic        init_done, ref_req, traffic_ok;

    int checks = 0;
    int errors = 0;
    int pre_at = -100000;
    int served = 0;
    int rise_at = 0;
    int pre_seen = 0;
    bit req_e = 1'b0;
    bit prev_take = 1'b0;

    always #4 clk = ~clk;

    sdr_bringup_seq #(
        .CLK_MHZ(MHZ), .BURST_CODE(3'b010), .WRAP_INTERLEAVE(1'b1),
        .CAS_LAT(2), .SINGLE_WRITE(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .sdr_cke(cke), .sdr_cs_n(cs_n), .sdr_ras_n(ras_n),
        .sdr_cas_n(cas_n), .sdr_we_n(we_n), .sdr_ba(ba), .sdr_addr(addr),
        .sdr_dqm(dqm), .init_done(init_done), .ref_req(ref_req),
        .ref_ack(ref_ack), .traffic_ok(traffic_ok)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pack(logic [3:0] c, logic [11:0] a, logic [1:0] m,
                                         logic d, logic q, logic t);
        return {1'b1, c, 2'b00, a, m, d, q, t};
    endfunction

    initial begin
        #(8 * 40000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  ec;
        logic [11:0] ea;
        bit          tok;
        string       tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10", "reset bus", {8'h0, cke, cs_n, ras_n, cas_n, we_n, ba, addr, dqm, init_done, ref_req, traffic_ok},
              {8'h0, pack(4'b0111, 12'h0, 2'b11, 1'b0, 1'b0, 1'b0)});
        rst = 1'b0;
        for (int n = 0; n <= LAST; n++) begin
            if (prev_take) begin
                req_e  = 1'b0;
                pre_at = n;
                served++;
            end
            if (n > D && ((n - D) % REFI) == 0) begin
                req_e   = 1'b1;
                rise_at = n;
            end
            ec = 4'b0111;
            ea = 12'h0;
            if (n < D) begin
                if (n == P) begin ec = 4'b0010; ea = 12'h400; end
                else if (n == P + RP) begin ec = 4'b0000; ea = MODE_EXP; end
                else if (n >= F && ((n - F) % RC) == 0) ec = 4'b0001;
            end else if (n == pre_at) begin
                ec = 4'b0010; ea = 12'h400;
            end else if (n == pre_at + RP) begin
                ec = 4'b0001;
            end
            tok = (n >= D) && !(n >= pre_at && n < pre_at + RP + RC);
            if (n < P) tag = "R1";
            else if (n == P) tag = "R2";
            else if (n < F) tag = "R3";
            else if (n < D) tag = "R5";
            else if (n == D) tag = "R6";
            else if (n >= pre_at && n < pre_at + RP + RC + 1) tag = "R8";
            else if (served >= 1 && ref_ack && !req_e) tag = "R9";
            else tag = "R7";
            check(tag, $sformatf("cycle %0d bus", n),
                  {8'h0, cke, cs_n, ras_n, cas_n, we_n, ba, addr, dqm, init_done, ref_req, traffic_ok},
                  {8'h0, pack(ec, ea, (n < D) ? 2'b11 : 2'b00, n >= D, req_e, tok)});
            if (n == P + RP) begin
                check("R4", "burst field", 32'(addr[2:0]), 32'd2);
                check("R4", "wrap bit", 32'(addr[3]), 32'd1);
                check("R4", "cas field", 32'(addr[6:4]), 32'd2);
                check("R4", "single write bit", 32'(addr[9]), 32'd1);
                check("R4", "unused bits", 32'({addr[11:10], addr[8:7]}), 32'd0);
            end
            if (init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0010) pre_seen++;
            // acknowledge policy for the next edge
            if (served == 0)      ref_ack = req_e;
            else if (served == 1) ref_ack = (req_e && n >= rise_at + 100) ||
                                            (n >= pre_at && n < pre_at + RP + RC);
            else if (served == 2) ref_ack = (n >= D + 2 * REFI - 50);
            else                  ref_ack = (n >= pre_at && n < pre_at + RP + RC);
            if (n == D + 500) ref_ack = 1'b1;  // stray acknowledge, R9
            prev_take = ref_ack && req_e && tok;
            @(negedge clk);
        end
        check("R8", "refreshes served", 32'(served), 32'd3);
        check("R9", "precharges after ready", 32'(pre_seen), 32'd3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule